// File: doc/BRIEF.md
# Ramp-Search Threshold Calibrator

This block finds a detection threshold by searching a 12-bit DAC code against an external comparator. It runs two passes. In the first pass the light source is switched on. The block writes codes 0, STEP, 2·STEP, … to the DAC until the comparator reports a trip, and stores that code as the bright level. In the second pass the light is off and the same search gives the dark level. The block then writes the midpoint of the two levels to the DAC and reports done.

Each code leaves through a valid/ready request to a separate serial writer. After every accepted write the block waits a fixed number of clock cycles for the analog output to settle. Only then does it look at the comparator, which reaches it through a synchronizer chain. If a pass climbs to its highest legal code with no trip, the block stops with an error flag. In that case it makes no midpoint write and returns to idle. The two captured codes stay visible on output ports between runs.

Top module: `thr_cal_seq`

## Requirements
- R1: After reset, light_en_o, dac_valid_o, done_o and err_o are 0, and bright_code_o and dark_code_o are 0.
- R2: A start_i pulse in idle switches light_en_o on and issues a first write with code 0.
- R3: While dac_valid_o is high and dac_ready_i is low, dac_valid_o stays high and dac_code_o does not change. The block advances only on a cycle where both are high.
- R4: The comparator is sampled SETTLE_CYC cycles after each accepted write, through a SYNC_STAGES-flop synchronizer. With dac_ready_i held high, consecutive accepted writes are exactly SETTLE_CYC+2 cycles apart.
- R5: When the comparator reads 0 at its sample, the next write carries the previous code plus STEP. Each pass starts from code 0.
- R6: The first comparator trip with the light on stores the current code on bright_code_o. It then turns light_en_o off and restarts the ramp from code 0.
- R7: The first comparator trip with the light off stores the current code on dark_code_o.
- R8: After the dark trip, the block writes (bright + dark) >> 1 to the DAC. The sum is formed on 13 bits, so it does not overflow. On acceptance of that write, done_o rises and the block returns to idle.
- R9: If a pass samples no trip at its last code, err_o rises and light_en_o goes to 0. No midpoint write follows, and the block returns to idle. The last code is the largest multiple of STEP not above 4095. A captured code that the failed pass would have written keeps its old value.
- R10: start_i is ignored while a calibration is running.
- R11: A new start clears done_o and err_o. done_o and err_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a calibration (idle only) |
| cmp_async_i | input | 1 | Asynchronous comparator result, 1 = tripped |
| light_en_o | output | 1 | Light source enable, high during the bright pass |
| dac_code_o | output | 12 | Code offered to the DAC writer |
| dac_valid_o | output | 1 | Write request |
| dac_ready_i | input | 1 | Writer accepts the code this cycle |
| done_o | output | 1 | Last calibration finished with a midpoint write |
| err_o | output | 1 | Last calibration ended with no trip in a pass |
| bright_code_o | output | 12 | Code captured in the light-on pass |
| dark_code_o | output | 12 | Code captured in the light-off pass |

## Verification
The assertions take for granted that the writer never withdraws dac_ready_i in a way that matters to the handshake. They also assume the comparator settles within the wait. In practice, SETTLE_CYC must be at least SYNC_STAGES for a code change to reach the sample point. The stimulus meets this with a comparator model that is a plain function of the last accepted code and the light enable. It runs with a settle wait longer than the synchronizer depth, and its ready patterns are either always high or a fixed stall rhythm.

// File: rtl/thr_cal_pkg.sv
package thr_cal_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_SETTLE,
        ST_SAMPLE,
        ST_MID
    } cal_state_e;
endpackage

// File: rtl/thr_cal_sync.sv
module thr_cal_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/thr_cal_timer.sv
module thr_cal_timer #(
    parameter int unsigned CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expired_o
);
    localparam int unsigned CW = $clog2(CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          act;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (load_i) begin
            t_d.cnt = CW'(CYC - 1);
            t_d.act = 1'b1;
        end else if (t_q.act) begin
            if (t_q.cnt == '0) t_d.act = 1'b0;
            else               t_d.cnt = t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign expired_o = t_q.act && (t_q.cnt == '0);
endmodule

// File: rtl/thr_cal_seq.sv
module thr_cal_seq
    import thr_cal_pkg::*;
#(
    parameter int unsigned CODE_W      = 12,
    parameter int unsigned STEP        = 1,
    parameter int unsigned SETTLE_CYC  = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cmp_async_i,
    output logic              light_en_o,
    output logic [CODE_W-1:0] dac_code_o,
    output logic              dac_valid_o,
    input  logic              dac_ready_i,
    output logic              done_o,
    output logic              err_o,
    output logic [CODE_W-1:0] bright_code_o,
    output logic [CODE_W-1:0] dark_code_o
);
    localparam int unsigned   CODE_MAX = (1 << CODE_W) - 1;
    localparam logic [CODE_W:0] LAST   = (CODE_W+1)'((CODE_MAX / STEP) * STEP);
    localparam logic [CODE_W:0] STEP_V = (CODE_W+1)'(STEP);

    typedef struct packed {
        cal_state_e        st;
        logic [CODE_W-1:0] code;
        logic [CODE_W-1:0] bright;
        logic [CODE_W-1:0] dark;
        logic              light;
        logic              done;
        logic              err;
    } seq_t;

    seq_t r_d, r_q;

    logic            cmp_s;
    logic            tmr_load;
    logic            tmr_exp;
    logic [CODE_W:0] mid_sum;
    logic [CODE_W:0] next_code;

    thr_cal_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (cmp_async_i),
        .q_o   (cmp_s)
    );

    thr_cal_timer #(.CYC(SETTLE_CYC)) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .expired_o (tmr_exp)
    );

    always_comb begin
        r_d       = r_q;
        tmr_load  = 1'b0;
        mid_sum   = {1'b0, r_q.bright} + {1'b0, r_q.code};
        next_code = {1'b0, r_q.code} + STEP_V;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st    = ST_WRITE;
                    r_d.code  = '0;
                    r_d.light = 1'b1;
                    r_d.done  = 1'b0;
                    r_d.err   = 1'b0;
                end
            end
            ST_WRITE: begin
                if (dac_ready_i) begin
                    r_d.st   = ST_SETTLE;
                    tmr_load = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (tmr_exp) r_d.st = ST_SAMPLE;
            end
            ST_SAMPLE: begin
                if (cmp_s) begin
                    if (r_q.light) begin
                        r_d.bright = r_q.code;
                        r_d.light  = 1'b0;
                        r_d.code   = '0;
                        r_d.st     = ST_WRITE;
                    end else begin
                        r_d.dark = r_q.code;
                        r_d.code = mid_sum[CODE_W:1];
                        r_d.st   = ST_MID;
                    end
                end else if (next_code > LAST) begin
                    r_d.err   = 1'b1;
                    r_d.light = 1'b0;
                    r_d.st    = ST_IDLE;
                end else begin
                    r_d.code = next_code[CODE_W-1:0];
                    r_d.st   = ST_WRITE;
                end
            end
            ST_MID: begin
                if (dac_ready_i) begin
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign light_en_o    = r_q.light;
    assign dac_code_o    = r_q.code;
    assign dac_valid_o   = (r_q.st == ST_WRITE) || (r_q.st == ST_MID);
    assign done_o        = r_q.done;
    assign err_o         = r_q.err;
    assign bright_code_o = r_q.bright;
    assign dark_code_o   = r_q.dark;
endmodule

// File: rtl/thr_cal_seq_chk.sv
module thr_cal_seq_chk #(
    parameter int unsigned CODE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              light_en_o,
    input logic [CODE_W-1:0] dac_code_o,
    input logic              dac_valid_o,
    input logic              dac_ready_i,
    input logic              done_o,
    input logic              err_o
);
    assert_valid_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_valid_o && !dac_ready_i) |=> (dac_valid_o && $stable(dac_code_o)));

    assert_first_write_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(light_en_o) |-> (dac_valid_o && dac_code_o == '0));

    assert_done_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(dac_valid_o && dac_ready_i));

    assert_err_light_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> (!light_en_o && !dac_valid_o));

    assert_done_err_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));
endmodule

bind thr_cal_seq thr_cal_seq_chk #(.CODE_W(CODE_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .light_en_o  (light_en_o),
    .dac_code_o  (dac_code_o),
    .dac_valid_o (dac_valid_o),
    .dac_ready_i (dac_ready_i),
    .done_o      (done_o),
    .err_o       (err_o)
);

// File: tb/test_thr_cal_seq.sv
module test_thr_cal_seq;
    localparam int CLK_PERIOD = 10;
    localparam int STEP       = 16;
    localparam int SETTLE     = 4;
    localparam int LAST       = (4095 / STEP) * STEP;
    localparam int VEC_N      = 7;
    localparam int VB[VEC_N]  = '{100, 4080, 0, 4095, 500, 4000, 33};
    localparam int VD[VEC_N]  = '{40,  0,    0, 10,   4090, 4080, 3000};
    localparam int VR[VEC_N]  = '{0,   1,    0, 0,    1,    0,    1};
    localparam int VS[VEC_N]  = '{0,   0,    0, 0,    0,    0,    1};

    logic        clk = 0;
    logic        rst_n = 0;
    logic        start_i = 0;
    logic        cmp_async_i = 0;
    logic        light_en_o;
    logic [11:0] dac_code_o;
    logic        dac_valid_o;
    logic        dac_ready_i = 0;
    logic        done_o, err_o;
    logic [11:0] bright_code_o, dark_code_o;

    int checks = 0, fails = 0;
    int cyc = 0, thr_b = 0, thr_d = 0, rdy_mode = 0;
    int last_code = 0, n_wr = 0, n_wr_light = 0, last_hs = -1, gap_min = 0, gap_max = 0;
    int hold_err = 0;
    logic prev_stall = 0;
    logic [11:0] prev_code = 0;
    int exp_b = 0, exp_d = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    thr_cal_seq #(.CODE_W(12), .STEP(STEP), .SETTLE_CYC(SETTLE), .SYNC_STAGES(2)) i_thr_cal_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_async_i(cmp_async_i),
        .light_en_o(light_en_o), .dac_code_o(dac_code_o), .dac_valid_o(dac_valid_o),
        .dac_ready_i(dac_ready_i), .done_o(done_o), .err_o(err_o),
        .bright_code_o(bright_code_o), .dark_code_o(dark_code_o));

    // writer and comparator model, all at the falling edge
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (prev_stall && (!dac_valid_o || dac_code_o != prev_code)) hold_err = hold_err + 1;
        dac_ready_i = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) == 2);
        prev_stall = dac_valid_o && !dac_ready_i;
        prev_code  = dac_code_o;
        if (dac_valid_o && dac_ready_i) begin
            last_code = int'(dac_code_o);
            n_wr = n_wr + 1;
            if (light_en_o) n_wr_light = n_wr_light + 1;
            if (last_hs >= 0) begin
                if (gap_min == 0 || cyc - last_hs < gap_min) gap_min = cyc - last_hs;
                if (cyc - last_hs > gap_max) gap_max = cyc - last_hs;
            end
            last_hs = cyc;
        end
        cmp_async_i = light_en_o ? (last_code >= thr_b) : (last_code >= thr_d);
    end

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int trip(input int thr);
        return ((thr + STEP - 1) / STEP) * STEP;
    endfunction

    task automatic run(input int v);
        int tb, td, wr_exp, wrl_exp;
        bit eb, ed, ok;
        thr_b = VB[v]; thr_d = VD[v]; rdy_mode = VR[v];
        tb = trip(thr_b); td = trip(thr_d);
        eb = tb > LAST; ed = td > LAST;
        n_wr = 0; n_wr_light = 0; last_hs = -1; gap_min = 0; gap_max = 0; hold_err = 0;
        @(negedge clk); start_i = 1;
        @(negedge clk); start_i = 0;
        check("R11 flags cleared on start", int'(done_o) + int'(err_o), 0);
        ok = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            start_i = (VS[v] != 0 && i == 50);
            if (done_o || err_o) begin ok = 1; break; end
        end
        start_i = 0;
        check("R9 watchdog", int'(ok), 1);
        if (eb) begin
            wrl_exp = LAST / STEP + 1; wr_exp = wrl_exp;
        end else begin
            exp_b = tb; wrl_exp = tb / STEP + 1;
            if (ed) wr_exp = wrl_exp + LAST / STEP + 1;
            else begin exp_d = td; wr_exp = wrl_exp + td / STEP + 2; end
        end
        check("R8/R9 done flag", int'(done_o), int'(!eb && !ed));
        check("R9 err flag", int'(err_o), int'(eb || ed));
        check("R6 bright code", int'(bright_code_o), exp_b);
        check("R7 dark code", int'(dark_code_o), exp_d);
        check("R5/R10 write count", n_wr, wr_exp);
        check("R6 light-on writes", n_wr_light, wrl_exp);
        check("R9 light off at end", int'(light_en_o), 0);
        check("R3 code held under stall", hold_err, 0);
        if (!eb && !ed) check("R8 midpoint written", last_code, (tb + td) >> 1);
        if (v == 0) begin
            check("R4 min write spacing", gap_min, SETTLE + 2);
            check("R4 max write spacing", gap_max, SETTLE + 2);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check("R1 reset light/valid", int'(light_en_o) + int'(dac_valid_o), 0);
        check("R1 reset done/err", int'(done_o) + int'(err_o), 0);
        check("R1 reset codes", int'(bright_code_o) + int'(dark_code_o), 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        check("R2 idle without start", int'(dac_valid_o) + int'(light_en_o), 0);
        @(negedge clk); start_i = 1;
        @(negedge clk); start_i = 0;
        check("R2 light on after start", int'(light_en_o), 1);
        check("R2 first code zero", int'(dac_valid_o && dac_code_o == 0), 1);
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        for (int v = 0; v < VEC_N; v++) run(v);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule